// File: doc/BRIEF.md
# Split-Access 64-bit Counter Bank

This block keeps seven 64-bit activity counters for a cryptographic datapath and exposes them on a 32-bit register port. Three counters tally requests (one per cycle that a pulse input is high), and four accumulate byte amounts of up to 16 bits per cycle. Every counter wraps modulo 2^64.

Each counter occupies one 8-byte slot and is seen on the bus as two 32-bit words. A 64-bit write is made of two accesses. The word written to the lower address only waits in a staging register. The write to the higher address then commits both halves to the counter in a single cycle. For reads, the access to the lower address returns one half and, in the same cycle, copies the other half into a shared snapshot register. The later read of the higher address returns that snapshot, so a counter that keeps running cannot tear between the two reads. A parameter chooses whether the most significant half sits at the lower or at the higher address.

Top module: `ctr64_split_bank`

## Requirements
- R1: Reset (synchronous, active high) clears all seven counters, the staging word and the snapshot word. After reset `rd_data` is 0 and `rd_valid` is 0.
- R2: Counter k sits in slot k at byte offsets 8k (lower word) and 8k+4 (higher word). Slot order: 0 requests dequeued, 1 outbound encrypt requests, 2 inbound decrypt requests, 3 bytes encrypted, 4 bytes protected, 5 bytes decrypted, 6 bytes validated. Address bits [1:0] are ignored. Slots 7 and above read as 0, and writes to them change neither the counters nor the staging word.
- R3: A write to the lower word of a slot only loads the staging word. No counter changes because of it.
- R4: A write to the higher word of slot k sets counter k in that same cycle to the 64-bit value formed from the staging word (lower address) and the written data (higher address). The staging word keeps its value after the commit.
- R5: With `HI_FIRST`=1 the lower-address word is bits 63:32 and the higher-address word is bits 31:0. With `HI_FIRST`=0 the lower-address word is bits 31:0 and the higher-address word is bits 63:32.
- R6: A read of the lower word of slot k returns that word of counter k and, from the same counter value, loads the snapshot with the higher-address word. A read of a higher word returns the snapshot, even if the counter changed in between. Nothing else changes the snapshot.
- R7: The snapshot is shared by all slots. A read of the higher word of any mapped slot returns whatever the last lower-word read captured, which may belong to another counter.
- R8: Request counters 0..2 add 1 in each cycle that `evt_req[k]` is high. Byte counters 3..6 add `bytes_enc`, `bytes_prot`, `bytes_dec` and `bytes_val` respectively in every cycle.
- R9: Counters wrap modulo 2^64: all-ones plus 1 gives 0.
- R10: When a commit and an increment hit the same counter in the same cycle, the counter takes the committed value and the increment is lost.
- R11: A read presented in cycle n gives `rd_data` and `rd_valid`=1 after the clock edge that ends cycle n. `rd_valid` is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address inside the bank |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| evt_req | input | 3 | Request pulses: [0] dequeued, [1] outbound encrypt, [2] inbound decrypt |
| bytes_enc | input | INC_W (16) | Bytes encrypted this cycle |
| bytes_prot | input | INC_W (16) | Bytes protected this cycle |
| bytes_dec | input | INC_W (16) | Bytes decrypted this cycle |
| bytes_val | input | INC_W (16) | Bytes validated this cycle |

## Verification
The properties assume that reset is high from the first clock edge and that bus and event inputs never carry unknown values. They also assume that a request pulse means exactly one count for that cycle. The stimulus holds reset from time zero and changes every input only on the falling clock edge, to fixed known values, with idle inputs at zero. Increments overlap bus accesses only where the test is about that overlap: the race between a commit and a count, and reads while a counter keeps running.

// File: rtl/ctr64_pkg.sv
package ctr64_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CNT_W      = 2 * WORD_W;
  localparam int unsigned BYTE_OFS_W = 3;            // 8 bytes per slot
  localparam int unsigned N_REQ      = 3;            // pulse counters
  localparam int unsigned N_BYTE     = 4;            // amount counters
  localparam int unsigned NUM_CTR    = N_REQ + N_BYTE;

  // Word shown at the lower byte address of a slot
  function automatic logic [WORD_W-1:0] lo_addr_word(input logic [CNT_W-1:0] v,
                                                     input bit hi_first);
    return hi_first ? v[CNT_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction

  // Word shown at the higher byte address of a slot
  function automatic logic [WORD_W-1:0] hi_addr_word(input logic [CNT_W-1:0] v,
                                                     input bit hi_first);
    return hi_first ? v[WORD_W-1:0] : v[CNT_W-1:WORD_W];
  endfunction

  // Rebuild a counter value from its two bus words
  function automatic logic [CNT_W-1:0] join_words(input logic [WORD_W-1:0] lo_w,
                                                  input logic [WORD_W-1:0] hi_w,
                                                  input bit hi_first);
    return hi_first ? {lo_w, hi_w} : {hi_w, lo_w};
  endfunction

endpackage

// File: rtl/ctr64_addr_dec.sv
module ctr64_addr_dec
  import ctr64_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned SLOT_W = ADDR_W - BYTE_OFS_W
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [SLOT_W-1:0] slot,
  output logic              rd_any,
  output logic              rd_lo,
  output logic              rd_hi,
  output logic              wr_lo,
  output logic              wr_hi
);

  logic mapped;
  logic hi_word;
  logic unused_addr_lsb;

  assign slot            = bus_addr[ADDR_W-1:BYTE_OFS_W];
  assign hi_word         = bus_addr[BYTE_OFS_W-1];
  assign unused_addr_lsb = ^bus_addr[BYTE_OFS_W-2:0];
  assign mapped          = (slot < SLOT_W'(NUM_CTR));

  assign rd_any = bus_valid & ~bus_write;
  assign rd_lo  = rd_any & mapped & ~hi_word;
  assign rd_hi  = rd_any & mapped &  hi_word;
  assign wr_lo  = bus_valid & bus_write & mapped & ~hi_word;
  assign wr_hi  = bus_valid & bus_write & mapped &  hi_word;

endmodule

// File: rtl/ctr64_counter.sv
module ctr64_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;                                  // bus commit wins
    end else begin
      cnt <= cnt + {{(CNT_W-INC_W){1'b0}}, inc};        // wraps mod 2^CNT_W
    end
  end

endmodule

// File: rtl/ctr64_write_stage.sv
module ctr64_write_stage
  import ctr64_pkg::*;
#(
  parameter bit HI_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] stage,
  output logic [CNT_W-1:0]  commit_val
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else if (wr_lo) begin
      stage <= wdata;
    end
  end

  assign commit_val = join_words(stage, wdata, HI_FIRST);

endmodule

// File: rtl/ctr64_read_port.sv
module ctr64_read_port
  import ctr64_pkg::*;
#(
  parameter int unsigned SLOT_W   = 3,
  parameter bit          HI_FIRST = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [SLOT_W-1:0]               slot,
  input  logic                            rd_any,
  input  logic                            rd_lo,
  input  logic                            rd_hi,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]   cnt,
  output logic [WORD_W-1:0]               rd_data,
  output logic                            rd_valid,
  output logic [WORD_W-1:0]               snap
);

  localparam int unsigned N_SLOT = 2 ** SLOT_W;

  logic [CNT_W-1:0] pad [N_SLOT];
  logic [CNT_W-1:0] sel;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_pad
    if (i < NUM_CTR) begin : g_real
      assign pad[i] = cnt[i];
    end else begin : g_hole
      assign pad[i] = '0;
    end
  end

  assign sel = pad[slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      snap     <= '0;
    end else begin
      rd_valid <= rd_any;
      if (rd_lo) begin
        rd_data <= lo_addr_word(sel, HI_FIRST);
        snap    <= hi_addr_word(sel, HI_FIRST);
      end else if (rd_hi) begin
        rd_data <= snap;
      end else if (rd_any) begin
        rd_data <= '0;                                  // unmapped slot
      end
    end
  end

endmodule

// File: rtl/ctr64_split_bank.sv
module ctr64_split_bank
  import ctr64_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned INC_W    = 16,
  parameter bit          HI_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic [2:0]        evt_req,
  input  logic [INC_W-1:0]  bytes_enc,
  input  logic [INC_W-1:0]  bytes_prot,
  input  logic [INC_W-1:0]  bytes_dec,
  input  logic [INC_W-1:0]  bytes_val
);

  localparam int unsigned SLOT_W = ADDR_W - BYTE_OFS_W;

  logic [SLOT_W-1:0]             slot;
  logic                          rd_any, rd_lo, rd_hi, wr_lo, wr_hi;
  logic [WORD_W-1:0]             stage_q;
  logic [CNT_W-1:0]              commit_val;
  logic [WORD_W-1:0]             snap_q;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [INC_W-1:0]              inc_v   [NUM_CTR];
  logic [INC_W-1:0]              bytes_v [N_BYTE];

  assign bytes_v[0] = bytes_enc;
  assign bytes_v[1] = bytes_prot;
  assign bytes_v[2] = bytes_dec;
  assign bytes_v[3] = bytes_val;

  ctr64_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .slot      (slot),
    .rd_any    (rd_any),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi)
  );

  ctr64_write_stage #(.HI_FIRST(HI_FIRST)) u_stage (
    .clk        (clk),
    .rst        (rst),
    .wr_lo      (wr_lo),
    .wdata      (bus_wdata),
    .stage      (stage_q),
    .commit_val (commit_val)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    if (k < N_REQ) begin : g_req
      assign inc_v[k] = INC_W'(evt_req[k]);
    end else begin : g_byte
      assign inc_v[k] = bytes_v[k-N_REQ];
    end

    ctr64_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (wr_hi && (slot == SLOT_W'(k))),
      .load_val (commit_val),
      .inc      (inc_v[k]),
      .cnt      (cnt_q[k])
    );
  end

  ctr64_read_port #(.SLOT_W(SLOT_W), .HI_FIRST(HI_FIRST)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .rd_any   (rd_any),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .cnt      (cnt_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .snap     (snap_q)
  );

endmodule

// File: rtl/ctr64_split_bank_chk.sv
module ctr64_split_bank_chk
  import ctr64_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter bit          HI_FIRST = 1'b1,
  localparam int unsigned SLOT_W  = ADDR_W - BYTE_OFS_W
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [WORD_W-1:0]             bus_wdata,
  input logic [2:0]                    evt_req,
  input logic                          rd_valid,
  input logic [WORD_W-1:0]             rd_data,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt,
  input logic [WORD_W-1:0]             stage,
  input logic [WORD_W-1:0]             snap
);

  logic [SLOT_W-1:0] c_slot;
  logic              c_mapped, c_rd, c_rd_lo, c_wr_lo, c_wr_hi;

  assign c_slot   = bus_addr[ADDR_W-1:BYTE_OFS_W];
  assign c_mapped = c_slot < SLOT_W'(NUM_CTR);
  assign c_rd     = bus_valid && !bus_write;
  assign c_rd_lo  = c_rd && c_mapped && !bus_addr[2];
  assign c_wr_lo  = bus_valid && bus_write && c_mapped && !bus_addr[2];
  assign c_wr_hi  = bus_valid && bus_write && c_mapped && bus_addr[2];

  // R1: the cycle after reset everything reads as cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !rd_valid && stage == '0 && snap == '0 && cnt == '0));

  // R11: read strobe appears one cycle after the read
  p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (rst)
    c_rd |=> rd_valid);

  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !c_rd |=> !rd_valid);

  // R6: snapshot only moves on a lower-word read
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !c_rd_lo |=> $stable(snap));

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_k
    // R4 / R10: commit lands in the next cycle, increments ignored
    p_commit_wins_r10: assert property (@(posedge clk) disable iff (rst)
      (c_wr_hi && c_slot == SLOT_W'(k)) |=>
        cnt[k] == join_words($past(stage), $past(bus_wdata), HI_FIRST));

    if (k < N_REQ) begin : g_req
      // R3: a lower-word write alone leaves an idle counter unchanged
      p_low_write_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (c_wr_lo && !evt_req[k]) |=> $stable(cnt[k]));

      // R8: one pulse, one count
      p_req_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_req[k] && !(c_wr_hi && c_slot == SLOT_W'(k))) |=>
          cnt[k] == $past(cnt[k]) + CNT_W'(1));
    end
  end

endmodule

bind ctr64_split_bank ctr64_split_bank_chk #(
  .ADDR_W   (ADDR_W),
  .HI_FIRST (HI_FIRST)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_req   (evt_req),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .cnt       (cnt_q),
  .stage     (stage_q),
  .snap      (snap_q)
);

// File: tb/sim_ctr64_split_bank.sv
module sim_ctr64_split_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  evt_req = '0;
  logic [15:0] bytes_enc = '0, bytes_prot = '0, bytes_dec = '0, bytes_val = '0;
  logic [31:0] r0, r1;
  logic        rv0, rv1;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;   // 100 MHz

  // u0: most significant half at the lower address; u1: reversed
  ctr64_split_bank #(.HI_FIRST(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(r0), .rd_valid(rv0),
    .evt_req(evt_req), .bytes_enc(bytes_enc), .bytes_prot(bytes_prot),
    .bytes_dec(bytes_dec), .bytes_val(bytes_val));

  ctr64_split_bank #(.HI_FIRST(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(r1), .rd_valid(rv1),
    .evt_req(evt_req), .bytes_enc(bytes_enc), .bytes_prot(bytes_prot),
    .bytes_dec(bytes_dec), .bytes_val(bytes_val));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d0, output logic [31:0] d1);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d0 = r0; d1 = r1;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a,
                        input logic [31:0] e0, input logic [31:0] e1);
    logic [31:0] d0, d1;
    rd(a, d0, d1);
    chk({tag, " u0"}, d0, e0);
    chk({tag, " u1"}, d1, e1);
  endtask

  typedef struct packed {
    logic        is_wr;
    logic [5:0]  addr;
    logic [31:0] wd;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam int NV = 16;
  localparam logic [102:0] TBL [NV] = '{
    {1'b1, 6'h08, 32'h11112222, 32'h0,        32'h0},        // R3 stage slot1
    {1'b0, 6'h08, 32'h0,        32'h0,        32'h0},        // R3 counter untouched
    {1'b1, 6'h0C, 32'h33334444, 32'h0,        32'h0},        // R4 commit
    {1'b0, 6'h08, 32'h0,        32'h11112222, 32'h11112222}, // R4
    {1'b0, 6'h0C, 32'h0,        32'h33334444, 32'h33334444}, // R6 snapshot
    {1'b1, 6'h30, 32'hAAAA0000, 32'h0,        32'h0},        // slot6 stage
    {1'b1, 6'h34, 32'h0000BBBB, 32'h0,        32'h0},
    {1'b0, 6'h32, 32'h0,        32'hAAAA0000, 32'hAAAA0000}, // R2 low bits ignored
    {1'b0, 6'h37, 32'h0,        32'h0000BBBB, 32'h0000BBBB}, // R2
    {1'b1, 6'h38, 32'hDEAD0000, 32'h0,        32'h0},        // R2 unmapped
    {1'b1, 6'h3C, 32'h12345678, 32'h0,        32'h0},        // R2 unmapped
    {1'b0, 6'h38, 32'h0,        32'h0,        32'h0},        // R2 reads 0
    {1'b0, 6'h3C, 32'h0,        32'h0,        32'h0},        // R2 reads 0
    {1'b1, 6'h04, 32'h55550000, 32'h0,        32'h0},        // R4 stage kept
    {1'b0, 6'h00, 32'h0,        32'hAAAA0000, 32'hAAAA0000}, // R4
    {1'b0, 6'h04, 32'h0,        32'h55550000, 32'h55550000}  // R4
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d0, d1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rd_data", r0 | r1, 32'h0);
    chk("R1 rd_valid", {31'h0, rv0 | rv1}, 32'h0);
    rd_chk("R1 snapshot", 6'h04, 32'h0, 32'h0);
    for (int k = 0; k < 7; k++) rd_chk("R1 counter", 6'(k * 8), 32'h0, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      if (v.is_wr) wr(v.addr, v.wd);
      else rd_chk($sformatf("R2/R3/R4/R6 vec%0d", i), v.addr, v.e0, v.e1);
    end

    // R11: strobe after read and after write
    rd(6'h00, d0, d1);
    chk("R11 rvalid after read", {31'h0, rv0 & rv1}, 32'h1);
    wr(6'h28, 32'h0);
    chk("R11 rvalid after write", {31'h0, rv0 | rv1}, 32'h0);

    // R8: request pulses and byte amounts
    evt_req = 3'b100; bytes_dec = 16'h0100; bytes_prot = 16'hFFFF;
    repeat (2) @(negedge clk);
    bytes_prot = '0;
    @(negedge clk);
    bytes_dec = '0;
    repeat (2) @(negedge clk);
    evt_req = '0;
    rd_chk("R8 req lo", 6'h10, 32'h0, 32'h5);
    rd_chk("R8 req hi", 6'h14, 32'h5, 32'h0);
    rd_chk("R8 prot lo", 6'h20, 32'h0, 32'h1FFFE);
    rd_chk("R8 prot hi", 6'h24, 32'h1FFFE, 32'h0);
    rd_chk("R8 dec lo", 6'h28, 32'h0, 32'h300);
    rd_chk("R8 dec hi", 6'h2C, 32'h300, 32'h0);

    // R5: carry shows which word holds the upper half
    wr(6'h18, 32'h0);
    wr(6'h1C, 32'hFFFFFFFF);
    bytes_enc = 16'h0001;
    @(negedge clk);
    bytes_enc = '0;
    rd_chk("R5 order lo", 6'h18, 32'h1, 32'h1);
    rd_chk("R5 order hi", 6'h1C, 32'h0, 32'hFFFFFFFF);

    // R6: coherent pair while the counter keeps running
    bytes_enc = 16'hFFFF;
    rd_chk("R6 live lo", 6'h18, 32'h1, 32'h1);
    repeat (3) @(negedge clk);
    rd_chk("R6 coherent hi", 6'h1C, 32'h0, 32'hFFFFFFFF);
    bytes_enc = '0;
    rd_chk("R6 final lo", 6'h18, 32'h1, 32'h0004FFFC);
    rd_chk("R6 final hi", 6'h1C, 32'h0004FFFB, 32'hFFFFFFFF);

    // R7: snapshot shared across slots
    rd_chk("R7 load", 6'h18, 32'h1, 32'h0004FFFC);
    rd_chk("R7 other slot hi", 6'h24, 32'h0004FFFB, 32'hFFFFFFFF);

    // R9: wrap
    wr(6'h00, 32'hFFFFFFFF);
    wr(6'h04, 32'hFFFFFFFF);
    evt_req = 3'b001;
    @(negedge clk);
    evt_req = '0;
    rd_chk("R9 wrap lo", 6'h00, 32'h0, 32'h0);
    rd_chk("R9 wrap hi", 6'h04, 32'h0, 32'h0);

    // R10: commit beats a simultaneous pulse
    wr(6'h08, 32'h00000001);
    evt_req = 3'b010;
    wr(6'h0C, 32'h00000007);
    evt_req = '0;
    rd_chk("R10 lo", 6'h08, 32'h1, 32'h1);
    rd_chk("R10 hi", 6'h0C, 32'h7, 32'h7);

    // R1: reset mid-run clears counters and the staging word
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R1 cleared lo", 6'h18, 32'h0, 32'h0);
    rd_chk("R1 cleared hi", 6'h1C, 32'h0, 32'h0);
    wr(6'h14, 32'h9);
    rd_chk("R1 stage cleared lo", 6'h10, 32'h0, 32'h0);
    rd_chk("R1 stage cleared hi", 6'h14, 32'h9, 32'h9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule